// File: doc/BRIEF.md
# OUT Endpoint Receive Bank Controller

This block tracks ownership of the receive banks behind a USB OUT endpoint. It runs with one bank or with all of its banks used in turn. The serial engine reports the end of each OUT data packet, with its length and an error indication. The controller decides between ACK and NAK. When it accepts a packet it marks the target bank full, records the packet length for that bank and raises a received-data flag.

Firmware works through a few strobes. One strobe clears the flag. A separate strobe releases the bank that firmware holds, after it has copied the data out of RAM. Releasing a bank moves firmware's view to the next bank in the ring. In multi-bank mode the serial engine can fill the other bank while firmware still holds the first one. The data RAM, CRC checking and token decoding are outside the block. The block tells the RAM which bank to write (`wr_bank_o`) and which bank firmware reads (`rd_bank_o`).

Top module: `out_ep_bank_ctrl`

## Requirements
- R1: An error-free packet end (`pkt_end_i`=1, `pkt_err_i`=0) that finds the receive bank free is answered on the next cycle with `hs_valid_o`=1 and `hs_ack_o`=1. On that same clock edge the bank becomes busy and `rx_flag_o` is set.
- R2: `irq_o` is 1 exactly when `rx_flag_o` is 1 and `irq_en_i` is 1.
- R3: A pulse on `fw_flag_clr_i` clears `rx_flag_o` on the next edge and leaves every bank's busy state, byte count and both bank pointers unchanged. If a flag-setting event occurs in the same cycle, the set wins.
- R4: A pulse on `fw_release_i` while the firmware bank is busy frees that bank and advances `rd_bank_o` to the next bank in the ring. A release while the firmware bank is free has no effect.
- R5: An error-free packet end that finds the receive bank busy is answered on the next cycle with `hs_valid_o`=1 and `hs_ack_o`=0 (NAK), and no state changes. The busy state is taken from before any release in the same cycle.
- R6: With `multi_bank_i`=1, the receive bank pointer `wr_bank_o` advances after each accepted packet. A second packet is therefore ACKed into the other bank while firmware holds the first one.
- R7: A packet end with `pkt_err_i`=1 produces no handshake (`hs_valid_o`=0) and changes no bank, pointer, count or flag.
- R8: Each bank captures `pkt_len_i` when it is filled. `byte_cnt_o` shows the captured count of the bank at `rd_bank_o`, and a count is held until the bank is filled again.
- R9: When a release moves firmware onto a bank that is already full, `rx_flag_o` is set on that edge. If the flag was never cleared, the two events merge into one flag, so firmware must clear the flag before releasing.
- R10: During and just after reset, all banks are free, both pointers and all counts are 0, and `rx_flag_o`, `hs_valid_o` and `hs_ack_o` are 0.
- R11: With `multi_bank_i`=0, both pointers stay at bank 0, and the endpoint behaves as a single bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| multi_bank_i | input | 1 | 1: use all NBANK banks in a ring; 0: bank 0 only |
| pkt_end_i | input | 1 | One-cycle pulse at the end of an OUT data packet |
| pkt_err_i | input | 1 | The ending packet had a receive error |
| pkt_len_i | input | CNT_W | Byte length of the ending packet |
| fw_flag_clr_i | input | 1 | Firmware strobe: clear the received-data flag |
| fw_release_i | input | 1 | Firmware strobe: release the held bank |
| irq_en_i | input | 1 | Received-data interrupt enable |
| hs_valid_o | output | 1 | A handshake is to be sent this cycle |
| hs_ack_o | output | 1 | Handshake kind: 1 ACK, 0 NAK |
| wr_bank_o | output | PW | Bank that the next packet is written into |
| rd_bank_o | output | PW | Bank that firmware holds or will read |
| bank_busy_o | output | 1 | Busy state of the bank at rd_bank_o |
| byte_cnt_o | output | CNT_W | Captured length of the bank at rd_bank_o |
| rx_flag_o | output | 1 | Received-data flag |
| irq_o | output | 1 | Endpoint interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- the flag rises whenever a bank turns busy;
- a flag clear never disturbs bank state;
- a packet into a busy bank always gets a NAK;
- a bad packet yields no handshake and no bank change;
- in single-bank mode a release returns firmware to bank 0.

Other behaviour shows up only in the bench scenarios, which compare against a reference model:
- the ring order of the two pointers over many packets;
- the byte count captured for each bank;
- the flag re-raised when a release lands on a full bank, and the merge when firmware releases without clearing;
- the priority between a release and a packet in the same cycle.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;
  typedef enum logic {
    HS_NAK = 1'b0,
    HS_ACK = 1'b1
  } hs_kind_e;

  typedef struct packed {
    logic valid;
    hs_kind_e kind;
  } hs_t;
endpackage

// File: rtl/out_ep_ring_ptr.sv
module out_ep_ring_ptr #(
  parameter int NBANK = 2,
  localparam int PW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          multi_i,
  input  logic          step_i,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] ptr_nxt_o
);
  localparam logic [PW-1:0] LAST = PW'(NBANK - 1);

  logic [PW-1:0] ptr_q;

  always_comb begin
    if (!multi_i || ptr_q >= LAST) ptr_nxt_o = '0;
    else                           ptr_nxt_o = ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (step_i) ptr_q <= ptr_nxt_o;
  end

  assign ptr_o = ptr_q;

  a_r11_single_stays_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !multi_i) |=> (ptr_q == '0));
endmodule

// File: rtl/out_ep_bank_slot.sv
module out_ep_bank_slot #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic             free_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (fill_i) begin
        busy_q <= 1'b1;
        cnt_q  <= len_i;
      end else if (free_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  // fill targets a free slot only, release a busy one only
  a_r1_fill_only_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> !busy_q);
  a_r4_free_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> busy_q);
  a_r8_cnt_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i |=> $stable(cnt_q));
endmodule

// File: rtl/out_ep_rx_flag.sv
module out_ep_rx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  a_r3_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/out_ep_bank_ctrl.sv
module out_ep_bank_ctrl
  import out_ep_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int CNT_W = 10,
  localparam int PW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             multi_bank_i,
  input  logic             pkt_end_i,
  input  logic             pkt_err_i,
  input  logic [CNT_W-1:0] pkt_len_i,
  input  logic             fw_flag_clr_i,
  input  logic             fw_release_i,
  input  logic             irq_en_i,
  output logic             hs_valid_o,
  output logic             hs_ack_o,
  output logic [PW-1:0]    wr_bank_o,
  output logic [PW-1:0]    rd_bank_o,
  output logic             bank_busy_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             rx_flag_o,
  output logic             irq_o
);
  logic [PW-1:0]    rx_ptr, fw_ptr, rx_ptr_nxt, fw_ptr_nxt;
  logic [NBANK-1:0] busy_vec, fill_vec, free_vec, busy_nxt;
  logic [CNT_W-1:0] cnt_arr [NBANK];
  logic             good_pkt, accept, rel_eff, relook, flag_set;
  hs_t              hs_q;

  assign good_pkt = pkt_end_i & ~pkt_err_i;
  assign accept   = good_pkt & ~busy_vec[rx_ptr];
  assign rel_eff  = fw_release_i & busy_vec[fw_ptr];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign fill_vec[b] = accept  && (rx_ptr == PW'(b));
    assign free_vec[b] = rel_eff && (fw_ptr == PW'(b));
    assign busy_nxt[b] = (busy_vec[b] | fill_vec[b]) & ~free_vec[b];

    out_ep_bank_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fill_i (fill_vec[b]),
      .free_i (free_vec[b]),
      .len_i  (pkt_len_i),
      .busy_o (busy_vec[b]),
      .cnt_o  (cnt_arr[b])
    );
  end

  out_ep_ring_ptr #(.NBANK(NBANK)) u_rx_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .multi_i   (multi_bank_i),
    .step_i    (accept),
    .ptr_o     (rx_ptr),
    .ptr_nxt_o (rx_ptr_nxt)
  );

  out_ep_ring_ptr #(.NBANK(NBANK)) u_fw_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .multi_i   (multi_bank_i),
    .step_i    (rel_eff),
    .ptr_o     (fw_ptr),
    .ptr_nxt_o (fw_ptr_nxt)
  );

  // release onto an already full bank re-raises the flag
  assign relook   = rel_eff & busy_nxt[fw_ptr_nxt];
  assign flag_set = accept | relook;

  out_ep_rx_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (fw_flag_clr_i),
    .en_i   (irq_en_i),
    .flag_o (rx_flag_o),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= '{valid: 1'b0, kind: HS_NAK};
    end else begin
      hs_q.valid <= good_pkt;
      hs_q.kind  <= accept ? HS_ACK : HS_NAK;
    end
  end

  assign hs_valid_o  = hs_q.valid;
  assign hs_ack_o    = hs_q.valid & (hs_q.kind == HS_ACK);
  assign wr_bank_o   = rx_ptr;
  assign rd_bank_o   = fw_ptr;
  assign bank_busy_o = busy_vec[fw_ptr];
  assign byte_cnt_o  = cnt_arr[fw_ptr];

  a_r1_busy_raises_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(busy_vec & ~$past(busy_vec))) |-> rx_flag_o);
  a_r3_clear_keeps_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_flag_clr_i && !fw_release_i && !pkt_end_i) |=>
      ($stable(busy_vec) && $stable(rx_ptr) && $stable(fw_ptr)));
  a_r5_nak_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_pkt && busy_vec[rx_ptr]) |=> (hs_valid_o && !hs_ack_o));
  a_r7_error_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_i && pkt_err_i && !fw_release_i) |=> (!hs_valid_o && $stable(busy_vec)));
  a_r6_ack_moves_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && multi_bank_i) |=> (rx_ptr != $past(rx_ptr)));
endmodule

// File: tb/out_ep_bank_ctrl_tb.sv
module out_ep_bank_ctrl_tb_top;
  localparam int NB = 2;
  localparam int CW = 10;
  localparam int PW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic multi = 1'b0, pe = 1'b0, perr = 1'b0, clr = 1'b0, rel = 1'b0, en = 1'b0;
  logic [CW-1:0] len = '0;
  logic hs_v, hs_a, busy_o, flag_o, irq_o;
  logic [PW-1:0] wr_b, rd_b;
  logic [CW-1:0] cnt_o;

  int n_chk = 0, n_fail = 0;

  // reference model state
  bit       m_busy [NB];
  int       m_cnt [NB];
  int       m_rxp, m_fwp;
  bit       m_flag, m_hsv, m_hsa;

  always #2 clk = ~clk;

  out_ep_bank_ctrl #(.NBANK(NB), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .multi_bank_i(multi),
    .pkt_end_i(pe), .pkt_err_i(perr), .pkt_len_i(len),
    .fw_flag_clr_i(clr), .fw_release_i(rel), .irq_en_i(en),
    .hs_valid_o(hs_v), .hs_ack_o(hs_a), .wr_bank_o(wr_b), .rd_bank_o(rd_b),
    .bank_busy_o(busy_o), .byte_cnt_o(cnt_o), .rx_flag_o(flag_o), .irq_o(irq_o)
  );

  function automatic int adv(int p, bit mb);
    return (!mb || p >= NB - 1) ? 0 : p + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_busy[b] = 0; m_cnt[b] = 0; end
    m_rxp = 0; m_fwp = 0; m_flag = 0; m_hsv = 0; m_hsa = 0;
  endtask

  task automatic check_all();
    chk("R7 hs_valid", hs_v, m_hsv);
    chk("R1_R5 hs_ack", hs_a, m_hsa);
    chk("R3_R9 rx_flag", flag_o, m_flag);
    chk("R2 irq", irq_o, m_flag & en);
    chk("R6 wr_bank", wr_b, m_rxp);
    chk("R4_R11 rd_bank", rd_b, m_fwp);
    chk("R1_R4 bank_busy", busy_o, m_busy[m_fwp]);
    chk("R8 byte_cnt", cnt_o, m_cnt[m_fwp]);
  endtask

  // check current outputs, then drive one cycle of stimulus and step the model
  task automatic cyc(bit i_pe, bit i_err, int i_len, bit i_clr, bit i_rel, bit i_en);
    bit acc, rel_e, relook;
    int fw_n;
    @(negedge clk);
    check_all();
    pe = i_pe; perr = i_err; len = CW'(i_len); clr = i_clr; rel = i_rel; en = i_en;
    acc   = i_pe && !i_err && !m_busy[m_rxp];
    rel_e = i_rel && m_busy[m_fwp];
    m_hsv = i_pe && !i_err;
    m_hsa = acc;
    if (acc) begin m_busy[m_rxp] = 1; m_cnt[m_rxp] = i_len & ((1 << CW) - 1); end
    if (rel_e) m_busy[m_fwp] = 0;
    fw_n   = rel_e ? adv(m_fwp, multi) : m_fwp;
    relook = rel_e && m_busy[fw_n];
    if (acc) m_rxp = adv(m_rxp, multi);
    m_fwp = fw_n;
    if (acc || relook) m_flag = 1;
    else if (i_clr)    m_flag = 0;
  endtask

  task automatic do_reset(bit mb);
    @(negedge clk);
    rst_n = 0; multi = mb;
    pe = 0; perr = 0; clr = 0; rel = 0; en = 0; len = '0;
    model_reset();
    @(negedge clk);
    chk("R10 reset hs_valid", hs_v, 0);
    chk("R10 reset flag", flag_o, 0);
    chk("R10 reset busy", busy_o, 0);
    chk("R10 reset rd_bank", rd_b, 0);
    chk("R10 reset wr_bank", wr_b, 0);
    chk("R10 reset cnt", cnt_o, 0);
    rst_n = 1;
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      int r = $urandom_range(0, 99);
      cyc(r < 35, $urandom_range(0, 9) == 0, $urandom_range(0, 1023),
          $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0, $urandom_range(0, 1));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // single bank directed (R11)
    do_reset(0);
    cyc(1, 0, 64, 0, 0, 1);   // R1 accept
    cyc(1, 0, 12, 0, 0, 1);   // R5 NAK, bank held
    cyc(1, 1, 5, 0, 0, 1);    // R7 error packet
    cyc(0, 0, 0, 1, 0, 1);    // R3 clear, bank stays busy
    cyc(0, 0, 0, 0, 1, 1);    // R4 release
    cyc(0, 0, 0, 0, 1, 0);    // R4 release of free bank ignored
    cyc(1, 0, 33, 0, 1, 1);   // R5 packet + release same cycle, bank free -> ACK
    cyc(1, 0, 7, 0, 1, 1);    // R5 release-same-cycle sees busy -> NAK
    cyc(0, 0, 0, 0, 0, 0);
    random_run(3000);
    // dual bank directed
    do_reset(1);
    cyc(1, 0, 100, 0, 0, 1);  // R6 bank0
    cyc(1, 0, 200, 0, 0, 1);  // R6 bank1 while fw holds bank0
    cyc(1, 0, 300, 0, 0, 1);  // R5 both full -> NAK
    cyc(0, 0, 0, 0, 1, 1);    // R9 release w/o clear: flag merges
    cyc(0, 0, 0, 1, 0, 1);    // R3 clear
    cyc(1, 0, 44, 0, 0, 1);   // R6 refill bank0
    cyc(0, 0, 0, 1, 0, 1);    // clear flag
    cyc(0, 0, 0, 0, 1, 1);    // R9 release onto full bank0 -> flag re-set
    cyc(0, 0, 0, 0, 0, 1);
    random_run(6000);
    cyc(0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule